// File: doc/BRIEF.md
# Parallel-to-Serial Transmit Shifter with Loopback Wrap

This block turns pre-encoded 10-bit line words into a serial bit stream. It runs entirely on the serial bit clock. A one-cycle byte strobe arrives once every ten bit clocks and marks the byte boundary. On the bit-clock edge where the strobe is high, the word on the parallel input is captured. One edge later it moves into a shift register. From there it leaves one bit per bit clock, least significant bit first. The block does no line coding of its own: any 10-bit pattern is sent as given.

A loopback control decides where the stream goes. When loopback is off, the stream drives the external line output and the internal wrap output stays low. When loopback is on, the stream goes to the wrap output, which feeds a local receiver, and the external line is held at logic 0. Both outputs are registered, and the loopback control is sampled on every bit-clock edge. If no new word is strobed in, the shift register drains and the active output idles at 0.

Top module: `ser_wrap_top`

## Requirements
- R1: A word is captured on the rising bit-clock edge where `byteStb` is high. Changes to `txWord` on any other edge do not affect what is sent.
- R2: Bit 0 of a captured word appears on the active serial output after the second rising edge that follows the capture edge, which is a fixed latency of two bit clocks.
- R3: Bits leave in order, bit 0 (the least significant bit) first and bit 9 last. Bit k appears after the edge numbered capture + 2 + k.
- R4: When strobes come exactly ten bit clocks apart, the words go out back to back with no gap and no repeated bit.
- R5: While `loopEn` was low at an edge, `serOut` carries the stream bit after that edge and `wrapOut` is 0.
- R6: While `loopEn` was high at an edge, `wrapOut` carries the stream bit after that edge and `serOut` is held at 0. The mode can change on any bit edge, including in the middle of a word.
- R7: When no further word is strobed in, both outputs are 0 once the last bit of the final word has been sent.
- R8: A synchronous active-high `rst` clears the held word and the shift register and drives both outputs to 0. A word captured before the reset is never sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bitClk | input | 1 | Serial bit clock, ten cycles per byte period |
| rst | input | 1 | Synchronous active-high reset |
| byteStb | input | 1 | Byte-boundary strobe; the word is captured on the edge where it is high |
| txWord | input | 10 | Pre-encoded parallel word, bit 0 sent first |
| loopEn | input | 1 | 1 sends the stream to the wrap output and holds the line at 0 |
| serOut | output | 1 | External serial line output |
| wrapOut | output | 1 | Internal wrap output toward the local receiver |

## Verification
The bound checker checks on every cycle that the two outputs are never high together, and that each output follows the loopback setting of the previous edge (R5, R6). It also checks reset clearing (R8) and the two-clock placement of bit 0 (R2). Full bit order (R3), the seamless joining of consecutive words (R4), the masking of `txWord` changes between strobes (R1), draining to idle (R7) and the discarding of a captured word by reset can only be shown by the bench's scenarios. In those scenarios a behavioural schedule of expected bits is compared with both outputs on every clock.

// File: rtl/ser_wrap_pkg.sv
package ser_wrap_pkg;
  localparam int unsigned WORD_W = 10;

  typedef struct packed {
    logic captureEn;  // latch parallel word into holding register
    logic loadEn;     // move held word into shift register
    logic wrapSel;    // steer stream to wrap path, park line at 0
  } ctlStrobes_t;
endpackage

// File: rtl/ser_wrap_ctrl.sv
module ser_wrap_ctrl
  import ser_wrap_pkg::*;
(
  input  logic        bitClk,
  input  logic        rst,
  input  logic        byteStb,
  input  logic        loopEn,
  output ctlStrobes_t ctl
);
  logic loadPend;

  // A strobe captured on one edge becomes a shift-register load on the next.
  always_ff @(posedge bitClk) begin
    if (rst) loadPend <= 1'b0;
    else     loadPend <= byteStb;
  end

  always_comb begin
    ctl.captureEn = byteStb & ~rst;
    ctl.loadEn    = loadPend;
    ctl.wrapSel   = loopEn;
  end
endmodule

// File: rtl/ser_wrap_dp.sv
module ser_wrap_dp
  import ser_wrap_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         bitClk,
  input  logic         rst,
  input  ctlStrobes_t  ctl,
  input  logic [W-1:0] txWord,
  output logic         serOut,
  output logic         wrapOut
);
  logic [W-1:0] holdReg;
  logic [W-1:0] shiftReg;
  logic         nextBit;

  assign nextBit = shiftReg[0];

  always_ff @(posedge bitClk) begin
    if (rst) begin
      holdReg <= '0;
    end else if (ctl.captureEn) begin
      holdReg <= txWord;
    end
  end

  // Load has priority over shifting; zeros fill from the top so an idle line drains to 0.
  always_ff @(posedge bitClk) begin
    if (rst)             shiftReg <= '0;
    else if (ctl.loadEn) shiftReg <= holdReg;
    else                 shiftReg <= {1'b0, shiftReg[W-1:1]};
  end

  always_ff @(posedge bitClk) begin
    if (rst) begin
      serOut  <= 1'b0;
      wrapOut <= 1'b0;
    end else begin
      serOut  <= ctl.wrapSel ? 1'b0 : nextBit;
      wrapOut <= ctl.wrapSel ? nextBit : 1'b0;
    end
  end
endmodule

// File: rtl/ser_wrap_top.sv
module ser_wrap_top
  import ser_wrap_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         bitClk,
  input  logic         rst,
  input  logic         byteStb,
  input  logic [W-1:0] txWord,
  input  logic         loopEn,
  output logic         serOut,
  output logic         wrapOut
);
  ctlStrobes_t ctl;

  ser_wrap_ctrl i_ctrl (
    .bitClk (bitClk),
    .rst    (rst),
    .byteStb(byteStb),
    .loopEn (loopEn),
    .ctl    (ctl)
  );

  ser_wrap_dp #(.W(W)) i_dp (
    .bitClk (bitClk),
    .rst    (rst),
    .ctl    (ctl),
    .txWord (txWord),
    .serOut (serOut),
    .wrapOut(wrapOut)
  );
endmodule

// File: rtl/ser_wrap_chk.sv
module ser_wrap_chk #(
  parameter int unsigned W = 10
) (
  input logic         bitClk,
  input logic         rst,
  input logic         byteStb,
  input logic [W-1:0] txWord,
  input logic         loopEn,
  input logic         serOut,
  input logic         wrapOut
);
  logic [2:0] sinceRst;

  always_ff @(posedge bitClk) begin
    if (rst)                 sinceRst <= 3'd0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R5 / R6: only one path may be active at a time
  p_one_path_r6: assert property (@(posedge bitClk) disable iff (rst)
    !(serOut && wrapOut));

  // R6: the line is parked at 0 after an edge with loopback on
  p_line_parked_r6: assert property (@(posedge bitClk) disable iff (rst)
    (sinceRst >= 3'd1 && $past(loopEn)) |-> !serOut);

  // R5: wrap path is silent after an edge with loopback off
  p_wrap_quiet_r5: assert property (@(posedge bitClk) disable iff (rst)
    (sinceRst >= 3'd1 && !$past(loopEn)) |-> !wrapOut);

  // R8: reset drives both outputs low on the next edge
  p_reset_clear_r8: assert property (@(posedge bitClk)
    rst |=> (!serOut && !wrapOut));

  // R2: bit 0 of a captured word is on the line two edges after capture
  p_first_bit_r2: assert property (@(posedge bitClk) disable iff (rst)
    (sinceRst >= 3'd4 && $past(byteStb, 3) && !$past(loopEn))
      |-> (serOut == $past(txWord[0], 3)));
endmodule

bind ser_wrap_top ser_wrap_chk #(.W(W)) i_chk (
  .bitClk (bitClk),
  .rst    (rst),
  .byteStb(byteStb),
  .txWord (txWord),
  .loopEn (loopEn),
  .serOut (serOut),
  .wrapOut(wrapOut)
);

// File: tb/test_ser_wrap_top.sv
module test_ser_wrap_top;
  logic       bitClk = 1'b0;
  logic       rst;
  logic       byteStb;
  logic [9:0] txWord;
  logic       loopEn;
  logic       serOut;
  logic       wrapOut;

  int checks = 0;
  int failures = 0;
  bit started = 0;
  bit done = 0;
  string curReq = "R5";

  always #5 bitClk = ~bitClk;

  ser_wrap_top i_ser_wrap_top (
    .bitClk (bitClk),
    .rst    (rst),
    .byteStb(byteStb),
    .txWord (txWord),
    .loopEn (loopEn),
    .serOut (serOut),
    .wrapOut(wrapOut)
  );

  // Behavioural reference: a schedule of line bits indexed by edge number.
  bit sched[int];
  int edgeNo = 0;
  bit expSer = 0;
  bit expWrap = 0;

  always @(posedge bitClk) begin
    bit b;
    edgeNo = edgeNo + 1;
    if (rst) begin
      sched.delete();
      expSer = 0;
      expWrap = 0;
    end else begin
      if (byteStb) begin
        for (int k = 0; k < 10; k++) sched[edgeNo + 2 + k] = txWord[k];
      end
      b = sched.exists(edgeNo) ? sched[edgeNo] : 1'b0;
      if (sched.exists(edgeNo)) sched.delete(edgeNo);
      expSer  = loopEn ? 1'b0 : b;
      expWrap = loopEn ? b : 1'b0;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge bitClk) begin
    if (started && !done) begin
      check(curReq, "serOut", serOut, expSer);
      check(curReq, "wrapOut", wrapOut, expWrap);
    end
  end

  function automatic logic [9:0] wordOf(input int i);
    return 10'((i * 10'h1A7) ^ 10'h155);
  endfunction

  task automatic sendStream(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      byteStb = 1'b1;
      txWord  = wordOf(base + i);
      @(negedge bitClk);
      byteStb = 1'b0;
      txWord  = ~wordOf(base + i);  // R1: must not reach the line
      repeat (9) @(negedge bitClk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge bitClk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; byteStb = 1'b0; txWord = '0; loopEn = 1'b0;
    repeat (3) @(negedge bitClk);
    check("R8", "serOut after reset", serOut, 0);
    check("R8", "wrapOut after reset", wrapOut, 0);
    rst = 1'b0;
    started = 1;
    repeat (2) @(negedge bitClk);

    // R2 / R3 / R1: single word, explicit latency check
    curReq = "R3";
    byteStb = 1'b1; txWord = 10'h2B5;
    @(negedge bitClk);               // capture edge E0 passed
    byteStb = 1'b0; txWord = 10'h14A;
    @(negedge bitClk);               // after E1
    check("R2", "serOut one edge after capture", serOut, 0);
    @(negedge bitClk);               // after E2
    check("R2", "bit0 two edges after capture", serOut, 1);
    @(negedge bitClk);
    check("R3", "bit1 of 2B5", serOut, 0);
    @(negedge bitClk);
    check("R3", "bit2 of 2B5", serOut, 1);
    repeat (12) @(negedge bitClk);

    // R4 / R5: back-to-back stream on the line
    curReq = "R4";
    sendStream(6, 1);
    // R7: drain to idle
    curReq = "R7";
    repeat (14) @(negedge bitClk);
    check("R7", "line idle", serOut, 0);

    // R6: wrap mode stream
    curReq = "R6";
    loopEn = 1'b1;
    sendStream(4, 20);
    // R6: mode change in the middle of words
    byteStb = 1'b1; txWord = 10'h3FF;
    @(negedge bitClk);
    byteStb = 1'b0;
    repeat (5) @(negedge bitClk);
    loopEn = 1'b0;
    repeat (3) @(negedge bitClk);
    check("R6", "line after switching back", serOut, 1);
    check("R6", "wrap after switching back", wrapOut, 0);
    loopEn = 1'b1;
    @(negedge bitClk);
    check("R6", "line parked", serOut, 0);
    repeat (14) @(negedge bitClk);

    // R8: reset in the middle of a word drops it
    curReq = "R8";
    loopEn = 1'b0;
    byteStb = 1'b1; txWord = 10'h3FF;
    @(negedge bitClk);
    byteStb = 1'b0;
    repeat (4) @(negedge bitClk);
    rst = 1'b1;
    @(negedge bitClk);
    rst = 1'b0;
    repeat (3) @(negedge bitClk);
    check("R8", "word dropped by reset", serOut, 0);
    repeat (12) @(negedge bitClk);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule